// File: doc/BRIEF.md
# Shared-Bus Converter Chip-Select Read Sequencer

This block sits on the host side of a group of serial sampling converters. The converters share one conversion-start line and one serial data return line, and each converter has its own active-low select. A single start pulse launches a common conversion on every converter. The sequencer then waits out the worst-case conversion time. After that it selects each converter in index order, clocks 16 bits out of it and presents each word together with the index of the converter it came from.

The protocol has strict rules that the sequencer enforces. Every select stays high while a conversion is in progress. The start line stays high until the last bit of the last converter has been read. Only one converter drives the shared line at any time, and there is a released gap between two converters. The start line and a select are never low together. Timing limits are given as parameters in system clock cycles. The serial clock runs at the system clock divided by 2·`SCLK_DIV`.

Top module: `adc_cs_read_ctrl`

## Requirements
- R1: After reset, and while idle, `convst_o` is low, every bit of `cs_n_o` is high, `sclk_o` is low, and `valid_o` and `done_o` are low.
- R2: A `start_i` pulse while idle drives `convst_o` high at the next clock edge. At that moment every select is high.
- R3: The first select falls exactly `T_CONV_MAX` cycles after `convst_o` rises, and all selects stay high until then. The wait is the larger of `T_CONV_MIN` and `T_CONV_MAX`.
- R4: Converters are selected in ascending index order, 0 to `N_DEV-1`. Bit k of `cs_n_o` selects converter k, and at most one select is low at a time. Between two converters there is exactly one cycle in which all selects are high.
- R5: Each select period holds exactly 16 `sclk_o` rising edges. `sclk_o` is low when the select falls and stays low while nothing is selected. Each high phase lasts `SCLK_DIV` cycles.
- R6: `sdo_i` is sampled on each `sclk_o` rising edge, MSB first. In the cycle of the 16th rising edge, `valid_o` pulses for one cycle. During that pulse, `data_o` holds the word and `dev_idx_o` holds the converter index.
- R7: A select is raised at the 16th `sclk_o` falling edge of its period, so each period contains 16 falling edges.
- R8: `convst_o` stays high until the last converter has been released. It falls in a cycle in which all selects are already high. `done_o` pulses in that same cycle, and the block returns to idle.
- R9: `convst_o` and any select are never low at the same time.
- R10: `start_i` has no effect while a cycle is in progress. No extra words appear and `done_o` pulses only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a conversion and read cycle (taken only while idle) |
| sdo_i | input | 1 | Shared serial data from the converters |
| convst_o | output | 1 | Common conversion-start line |
| cs_n_o | output | N_DEV | Active-low select, one bit per converter |
| sclk_o | output | 1 | Serial clock |
| data_o | output | DATA_W | Assembled word |
| dev_idx_o | output | IDX_W | Index of the converter for `data_o` |
| valid_o | output | 1 | One-cycle strobe for `data_o` and `dev_idx_o` |
| done_o | output | 1 | One-cycle pulse when the cycle completes |

## Verification
The bench builds the block with three converters, `SCLK_DIV` = 2, `T_CONV_MIN` = 3 and `T_CONV_MAX` = 10. With this configuration a full cycle takes about two hundred clocks, so twenty rounds can be run. Those rounds cover all-zero, all-one and alternating words, and a walking single bit that visits every bit position of every converter. Both the normal and the inverted form of the walking bit are used. The small converter count exercises the inter-device gap and the final release twice per round. Some rounds add stray start pulses during the conversion wait and during shifting.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } acr_state_e;
endpackage

// File: rtl/acr_timer.sv
module acr_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/acr_shreg.sv
module acr_shreg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/adc_cs_read_ctrl.sv
module adc_cs_read_ctrl #(
  parameter int N_DEV      = 4,
  parameter int DATA_W     = 16,
  parameter int SCLK_DIV   = 2,
  parameter int T_CONV_MIN = 50,
  parameter int T_CONV_MAX = 900,
  parameter int IDX_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              convst_o,
  output logic [N_DEV-1:0]  cs_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic [IDX_W-1:0]  dev_idx_o,
  output logic              valid_o,
  output logic              done_o
);
  import acr_pkg::*;

  localparam int CONV_WAIT = (T_CONV_MAX > T_CONV_MIN) ? T_CONV_MAX : T_CONV_MIN;
  localparam int CW        = $clog2(CONV_WAIT) + 1;
  localparam int HW        = $clog2(SCLK_DIV) + 1;
  localparam int PH_W      = $clog2(2 * DATA_W);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(2 * DATA_W - 1);
  localparam logic [N_DEV-1:0] ONE     = N_DEV'(1);

  acr_state_e       state_q;
  logic [IDX_W-1:0] dev_q, dev_nx;
  logic [PH_W-1:0]  ph_q;
  logic             conv_ld, conv_zero, half_ld, half_zero;
  logic             tick, shift_en, last_ph, last_dev;

  always_comb begin
    dev_nx   = dev_q + IDX_W'(1);
    last_dev = (dev_q == IDX_W'(N_DEV - 1));
    last_ph  = (ph_q == PH_LAST);
    conv_ld  = (state_q == ST_IDLE) && start_i;
    tick     = (state_q == ST_SHIFT) && half_zero;
    shift_en = tick && !ph_q[0];  // sclk rising edge
    half_ld  = ((state_q == ST_CONV) && conv_zero) ||
               (tick && !last_ph) ||
               ((state_q == ST_GAP) && !last_dev);
  end

  acr_timer #(.W(CW)) u_conv_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (conv_ld),
    .val_i  (CW'(CONV_WAIT - 1)),
    .zero_o (conv_zero)
  );

  acr_timer #(.W(HW)) u_half_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (half_ld),
    .val_i  (HW'(SCLK_DIV - 1)),
    .zero_o (half_zero)
  );

  acr_shreg #(.W(DATA_W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (shift_en),
    .bit_i  (sdo_i),
    .q_o    (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      convst_o <= 1'b0;
      cs_n_o   <= '1;
      sclk_o   <= 1'b0;
      dev_q    <= '0;
      ph_q     <= '0;
      valid_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          convst_o <= 1'b1;
          dev_q    <= '0;
          state_q  <= ST_CONV;
        end
        ST_CONV: if (conv_zero) begin
          cs_n_o  <= ~ONE;
          ph_q    <= '0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (half_zero) begin
          sclk_o <= ~ph_q[0];
          if (shift_en && ph_q == PH_LAST - PH_W'(1)) valid_o <= 1'b1;
          if (last_ph) begin
            cs_n_o  <= '1;  // release with the final falling edge
            state_q <= ST_GAP;
          end else begin
            ph_q <= ph_q + PH_W'(1);
          end
        end
        ST_GAP: if (last_dev) begin
          convst_o <= 1'b0;  // all selects already high
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end else begin
          dev_q   <= dev_nx;
          cs_n_o  <= ~(ONE << dev_nx);
          ph_q    <= '0;
          state_q <= ST_SHIFT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dev_idx_o = dev_q;
endmodule

// File: rtl/acr_read_chk.sv
module acr_read_chk #(
  parameter int N_DEV      = 4,
  parameter int T_CONV_MIN = 50,
  parameter int T_CONV_MAX = 900
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             convst_o,
  input logic [N_DEV-1:0] cs_n_o,
  input logic             sclk_o,
  input logic             valid_o,
  input logic             done_o
);
  localparam int WAIT = (T_CONV_MAX > T_CONV_MIN) ? T_CONV_MAX : T_CONV_MIN;

  int win_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           win_q <= 0;
    else if (!convst_o)    win_q <= 0;
    else if (win_q < WAIT) win_q <= win_q + 1;
  end

  // R1
  idle_sclk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &cs_n_o |-> !sclk_o);
  // R2
  start_all_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(convst_o) |-> &cs_n_o);
  // R3
  conv_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_n_o) |-> win_q >= WAIT);
  // R4
  one_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  // R4
  no_direct_hop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&cs_n_o) && !(&$past(cs_n_o))) |-> cs_n_o == $past(cs_n_o));
  // R6
  valid_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> convst_o && !(&cs_n_o));
  // R8
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !convst_o && &cs_n_o && $past(&cs_n_o));
  // R9
  no_overlap_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !convst_o |-> &cs_n_o);
endmodule

bind adc_cs_read_ctrl acr_read_chk #(
  .N_DEV      (N_DEV),
  .T_CONV_MIN (T_CONV_MIN),
  .T_CONV_MAX (T_CONV_MAX)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .convst_o (convst_o),
  .cs_n_o   (cs_n_o),
  .sclk_o   (sclk_o),
  .valid_o  (valid_o),
  .done_o   (done_o)
);

// File: tb/adc_cs_read_ctrl_test.sv
module adc_cs_read_ctrl_test;
  localparam int N    = 3;
  localparam int DW   = 16;
  localparam int DIV  = 2;
  localparam int TMIN = 3;
  localparam int TMAX = 10;
  localparam int IW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sdo;
  logic          convst, sclk, valid, done;
  logic [N-1:0]  cs_n;
  logic [DW-1:0] data;
  logic [IW-1:0] idx;

  always #5 clk = ~clk;

  adc_cs_read_ctrl #(
    .N_DEV(N), .DATA_W(DW), .SCLK_DIV(DIV), .T_CONV_MIN(TMIN), .T_CONV_MAX(TMAX)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sdo_i(sdo),
    .convst_o(convst), .cs_n_o(cs_n), .sclk_o(sclk), .data_o(data),
    .dev_idx_o(idx), .valid_o(valid), .done_o(done)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // converter models: MSB on select, shift on sclk falling edge
  logic [DW-1:0] dev_val [N];
  int ptr [N];
  for (genvar g = 0; g < N; g++) begin : g_dev
    initial ptr[g] = DW - 1;
    always @(negedge sclk or posedge cs_n[g]) begin
      if (cs_n[g])         ptr[g] = DW - 1;
      else if (ptr[g] > 0) ptr[g] = ptr[g] - 1;
    end
  end
  always_comb begin
    sdo = 1'b0;
    for (int k = 0; k < N; k++) if (!cs_n[k]) sdo = dev_val[k][ptr[k]];
  end

  // monitor
  bit mon_en = 1'b0;
  bit prev_sclk, prev_convst, seen_low;
  logic [N-1:0] prev_cs = '1;
  int rises, falls, hi_run, gap, lat, exp_sel, exp_vidx, frames, dones;

  always @(negedge clk) if (mon_en) begin
    if (!convst && !(&cs_n)) chk(0, "R9 convst and select both low", cs_n, '1);
    if ($countones(~cs_n) > 1) chk(0, "R4 several selects low", cs_n, '1);
    if (convst && !prev_convst) chk(&cs_n, "R2 selects high at convst rise", cs_n, '1);
    if (convst && (&cs_n) && !seen_low) lat++;
    if (!(&cs_n) && (&prev_cs)) begin
      if (!seen_low) chk(lat == TMAX, "R3 select latency", lat, TMAX);
      else chk(gap == 1, "R4 release gap", gap, 1);
      seen_low = 1'b1;
      chk(cs_n == ~(N'(1) << exp_sel), "R4 selection order", cs_n, ~(N'(1) << exp_sel));
      chk(!sclk, "R5 sclk low at select", sclk, 0);
      exp_sel++;
      rises = 0; falls = 0;
    end
    if (sclk && !prev_sclk) begin rises++; hi_run = 1; end
    else if (sclk) hi_run++;
    if (!sclk && prev_sclk) begin
      falls++;
      chk(hi_run == DIV, "R5 sclk high phase", hi_run, DIV);
    end
    if (sclk && (&cs_n)) chk(0, "R5 sclk with no select", sclk, 0);
    if ((&cs_n) && !(&prev_cs)) begin
      chk(rises == 16, "R5 rising edges per select", rises, 16);
      chk(falls == 16, "R7 falling edges per select", falls, 16);
      gap = 1;
    end else if (&cs_n) gap++;
    if (valid) begin
      chk(idx == IW'(exp_vidx), "R6 device index", idx, exp_vidx);
      chk(data == dev_val[exp_vidx % N], "R6 data word", data, dev_val[exp_vidx % N]);
      chk(rises == 16 && sclk, "R6 strobe at 16th rise", rises, 16);
      exp_vidx++; frames++;
    end
    if (done) begin
      dones++;
      chk(!convst && prev_convst && (&prev_cs) && (&cs_n), "R8 done with release",
          {convst, prev_convst}, 2'b01);
    end else if (prev_convst && !convst) chk(0, "R8 convst fell without done", convst, 1);
    prev_sclk = sclk; prev_convst = convst; prev_cs = cs_n;
  end

  function automatic logic [DW-1:0] pattern(input int r, input int k);
    logic [DW-1:0] v;
    case (r)
      0: v = 16'h0000;
      1: v = 16'hFFFF;
      2: v = (k % 2 == 0) ? 16'hAAAA : 16'h5555;
      default: begin
        v = 16'h0001 << ((r * 3 + k) % 16);
        if (r % 2 == 1) v = ~v;
      end
    endcase
    return v;
  endfunction

  task automatic run_round(input int r, input int stray);
    for (int k = 0; k < N; k++) dev_val[k] = pattern(r, k);
    lat = 0; seen_low = 1'b0; exp_sel = 0; exp_vidx = 0; frames = 0; dones = 0;
    @(negedge clk);
    chk(!convst && (&cs_n), "R1 idle before start", {convst, cs_n}, {1'b0, {N{1'b1}}});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(convst == 1'b1, "R2 convst raised", convst, 1);
    if (stray > 0) begin
      // R10: stray start while busy
      repeat (stray) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 5000 && dones == 0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(frames == N, "R10 words per cycle", frames, N);
    chk(dones == 1, "R10 single done", dones, 1);
    chk(exp_sel == N, "R4 selects per cycle", exp_sel, N);
    chk(!convst && (&cs_n) && !sclk, "R8 back to idle", {convst, sclk}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!convst && (&cs_n) && !sclk && !valid && !done, "R1 reset state",
        {convst, cs_n, sclk, valid, done}, {1'b0, {N{1'b1}}, 3'b000});
    rst_n = 1'b1;
    @(negedge clk);
    prev_cs = cs_n; prev_sclk = sclk; prev_convst = convst;
    mon_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(!convst && (&cs_n) && !sclk && !valid && !done, "R1 idle after reset",
        {convst, cs_n, sclk, valid, done}, {1'b0, {N{1'b1}}, 3'b000});
    for (int r = 0; r < 20; r++)
      run_round(r, (r % 4 == 1) ? 2 : (r % 4 == 3) ? 40 : 0);
    mon_en = 1'b0;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule